// File: doc/BRIEF.md
# Linear NRZ Clock Phase Comparator

This block measures how far each edge of an incoming NRZ bit stream sits from the rising edge of a local recovered clock. For every data edge it emits a phase pulse whose width is proportional to that distance. After the phase pulse it emits a compensating pulse of fixed width. An external network weights and subtracts the two pulses and then filters the result. The filtered value is then proportional to the phase error. The block also returns the data bit retimed to the rising clock edge.

When two consecutive bits are equal, neither pulse appears. The difference therefore rests at the mid level, which means "no phase error", and does not swing to one side. The loop gain scales with transition density: the share of bit boundaries that actually carry an edge.

A parameter selects how the compensating pulse is built:
- **Half-period style:** a falling-edge flip-flop produces a pulse of half a clock period. This style relies on a 50 % clock duty cycle.
- **Full-period style:** a rising-edge-only pulse lasts one full period. The downstream summing stage must weight it at half. This style works with any clock duty cycle.

The averaged output lands at 0.25, 0.5 or 0.75 of full scale when the clock rising edge falls on the data edge, the bit centre or the bit end.

Top module: `nrz_lin_phase_cmp`

## Requirements
- R1: `rdata_o` equals the value `sdata_i` held at the most recent rising edge of `clk_i` while reset was low. It is updated at that edge.
- R2: After a data edge, `phase_o` is high from the data edge until the next rising edge of `clk_i`. With a clock period of P, an edge at offset k after a rising edge gives a pulse width of P−k.
- R3: If a bit equals the previous bit, `phase_o` and `comp_o` both stay low for that bit period.
- R4: With `COMP_STYLE` = half period (encoding 2'd0), `comp_o` rises at the rising edge that ends a phase pulse. It lasts exactly P/2, ending at the following falling edge.
- R5: With `COMP_STYLE` = full period (encoding 2'd1), `comp_o` rises at the rising edge that ends a phase pulse. It lasts exactly P, ending at the next rising edge.
- R6: In half-period style, a data edge that lands on the falling clock edge gives phase and compensating pulses of equal width, so the net output is zero.
- R7: While `rst_i` is high, `phase_o` and `comp_o` are low whatever `sdata_i` does. A rising edge with reset high clears `rdata_o` to 0.
- R8: A falling data edge (1 to 0) gives the same pulse widths as a rising data edge (0 to 1) at the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local recovered clock; rising edge samples data |
| rst_i | input | 1 | Synchronous reset, active high |
| sdata_i | input | 1 | Asynchronous incoming NRZ data |
| rdata_o | output | 1 | Data retimed to the rising clock edge |
| phase_o | output | 1 | Variable-width phase pulse |
| comp_o | output | 1 | Fixed-width compensating pulse |

## Verification
The outputs become valid at different times after a data edge:
- `phase_o` follows a data edge with no clock delay and drops at the next rising edge, where `rdata_o` takes the new bit.
- `comp_o` then lasts until the following falling edge (half-period style) or the next rising edge (full-period style).

For each bit, the bench moves the data edge to every integer offset inside the period and waits for the following rising edge. It then samples both instances at half-unit offsets across a two-period window. This way, no sample coincides with a clock edge or a data change.

The bench counts high samples to obtain each pulse width and compares it with P−k, P/2 or P, or with zero for a repeated bit. It checks `rdata_o` half a unit after the rising edge that ends the phase pulse.

// File: rtl/nrz_pd_pkg.sv
`timescale 1ns/100ps
package nrz_pd_pkg;
   typedef enum logic [1:0] {
      COMP_HALF = 2'd0,
      COMP_FULL = 2'd1
   } comp_style_e;
endpackage

// File: rtl/nrz_retime.sv
`timescale 1ns/100ps
module nrz_retime #(
   parameter int WIDTH = 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i) q_o <= '0;
      else       q_o <= d_i;
   end
endmodule

// File: rtl/nrz_comp_gen.sv
`timescale 1ns/100ps
module nrz_comp_gen
   import nrz_pd_pkg::*;
#(
   parameter comp_style_e COMP_STYLE = COMP_HALF
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic ret_i,
   output logic comp_o
);
   logic delayed_q;

   generate
      if (COMP_STYLE == COMP_HALF) begin : g_half
         // Copy taken half a period later; pulse spans rise to fall.
         always_ff @(negedge clk_i) begin
            if (rst_i) delayed_q <= 1'b0;
            else       delayed_q <= ret_i;
         end
      end else if (COMP_STYLE == COMP_FULL) begin : g_full
         // Copy taken one period later; pulse spans rise to rise.
         always_ff @(posedge clk_i) begin
            if (rst_i) delayed_q <= 1'b0;
            else       delayed_q <= ret_i;
         end
      end else begin : g_bad
         $error("nrz_comp_gen: unsupported COMP_STYLE");
         assign delayed_q = 1'b0;
      end
   endgenerate

   assign comp_o = (ret_i ^ delayed_q) & ~rst_i;
endmodule

// File: rtl/nrz_lin_phase_cmp.sv
`timescale 1ns/100ps
module nrz_lin_phase_cmp
   import nrz_pd_pkg::*;
#(
   parameter comp_style_e COMP_STYLE = COMP_HALF
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic sdata_i,
   output logic rdata_o,
   output logic phase_o,
   output logic comp_o
);
   logic ret_q;

   nrz_retime #(.WIDTH(1)) u_retime (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (sdata_i),
      .q_o   (ret_q)
   );

   // High from the data edge until the rising edge that retimes it.
   assign phase_o = (sdata_i ^ ret_q) & ~rst_i;
   assign rdata_o = ret_q;

   nrz_comp_gen #(.COMP_STYLE(COMP_STYLE)) u_comp (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .ret_i  (ret_q),
      .comp_o (comp_o)
   );
endmodule

// File: rtl/nrz_lin_phase_cmp_chk.sv
`timescale 1ns/100ps
module nrz_lin_phase_cmp_chk
   import nrz_pd_pkg::*;
#(
   parameter comp_style_e COMP_STYLE = COMP_HALF
) (
   input logic clk_i,
   input logic rst_i,
   input logic sdata_i,
   input logic rdata_o,
   input logic phase_o,
   input logic comp_o
);
   p_retime_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (rdata_o == $past(sdata_i)));

   p_phase_predicts_edge_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      phase_o |=> (rdata_o != $past(rdata_o)));

   p_no_edge_no_change_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !phase_o |=> $stable(rdata_o));

   p_comp_after_change_r5: assert property (@(negedge clk_i) disable iff (rst_i)
      comp_o == (rdata_o != $past(rdata_o)));

   p_reset_quiet_r7: assert property (@(posedge clk_i)
      rst_i |-> (!phase_o && !comp_o));

   generate
      if (COMP_STYLE == COMP_HALF) begin : g_half_chk
         p_comp_low_at_rise_r4: assert property (@(posedge clk_i) disable iff (rst_i)
            !comp_o);
      end
   endgenerate
endmodule

bind nrz_lin_phase_cmp nrz_lin_phase_cmp_chk #(.COMP_STYLE(COMP_STYLE)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .sdata_i (sdata_i),
   .rdata_o (rdata_o),
   .phase_o (phase_o),
   .comp_o  (comp_o)
);

// File: tb/nrz_lin_phase_cmp_test.sv
`timescale 1ns/100ps
module nrz_lin_phase_cmp_test;
   import nrz_pd_pkg::*;

   localparam int CLK_PERIOD = 20;
   localparam int HALF_P     = CLK_PERIOD / 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sdata = 1'b0;
   logic rd_h, ph_h, cp_h, rd_f, ph_f, cp_f;

   int n_checks = 0;
   int n_fail   = 0;
   logic prev_bit = 1'b0;

   nrz_lin_phase_cmp #(.COMP_STYLE(COMP_HALF)) uut (
      .clk_i(clk), .rst_i(rst), .sdata_i(sdata),
      .rdata_o(rd_h), .phase_o(ph_h), .comp_o(cp_h));

   nrz_lin_phase_cmp #(.COMP_STYLE(COMP_FULL)) uut_full (
      .clk_i(clk), .rst_i(rst), .sdata_i(sdata),
      .rdata_o(rd_f), .phase_o(ph_f), .comp_o(cp_f));

   always #(HALF_P) clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Edge at offset k after a rising edge; window covers two periods.
   task automatic run_bit(input int k, input logic nv);
      int ph_hc = 0, ph_fc = 0, cp_hc = 0, cp_fc = 0;
      logic rh = 1'b0, rf = 1'b0;
      bit chg = (nv != prev_bit);
      string tag;
      @(posedge clk);
      for (int s = 0; s < 2*CLK_PERIOD; s++) begin
         if (s == k) sdata = nv;
         #0.5;
         ph_hc += int'(ph_h); ph_fc += int'(ph_f);
         cp_hc += int'(cp_h); cp_fc += int'(cp_f);
         if (s == CLK_PERIOD) begin rh = rd_h; rf = rd_f; end
         if (s < 2*CLK_PERIOD-1) #0.5;
      end
      tag = !chg ? "R3" : (nv ? "R2" : "R8");
      check(ph_hc == (chg ? CLK_PERIOD-k : 0), {tag, " phase half"}, ph_hc, chg ? CLK_PERIOD-k : 0);
      check(ph_fc == (chg ? CLK_PERIOD-k : 0), {tag, " phase full"}, ph_fc, chg ? CLK_PERIOD-k : 0);
      check(cp_hc == (chg ? HALF_P : 0), chg ? "R4 comp half" : "R3 comp half", cp_hc, chg ? HALF_P : 0);
      check(cp_fc == (chg ? CLK_PERIOD : 0), chg ? "R5 comp full" : "R3 comp full", cp_fc, chg ? CLK_PERIOD : 0);
      check(rh == nv, "R1 retimed half", int'(rh), int'(nv));
      check(rf == nv, "R1 retimed full", int'(rf), int'(nv));
      if (chg && k == HALF_P)
         check(ph_hc == cp_hc, "R6 net zero at falling edge", ph_hc - cp_hc, 0);
      prev_bit = nv;
   endtask

   initial begin
      // R7: reset holds pulses low despite data activity
      repeat (2) @(posedge clk);
      for (int i = 0; i < 4; i++) begin
         #3; sdata = ~sdata;
         #1;
         check(!ph_h && !cp_h && !ph_f && !cp_f, "R7 pulses in reset",
               int'(ph_h | cp_h | ph_f | cp_f), 0);
         check(!rd_h && !rd_f, "R7 retimed cleared", int'(rd_h | rd_f), 0);
         @(posedge clk);
      end
      sdata = 1'b0;
      #1; rst = 1'b0;
      @(posedge clk); #1;
      check(!rd_h && !rd_f && !ph_h && !cp_h, "R7 state after reset",
            int'(rd_h | rd_f | ph_h | cp_h), 0);
      prev_bit = 1'b0;
      for (int k = 1; k < CLK_PERIOD; k++) begin
         run_bit(k, 1'b1);
         run_bit(k, 1'b1);
         run_bit(k, 1'b0);
         run_bit(k, 1'b0);
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule